// File: doc/BRIEF.md
# Soft Mute Gain Ramp Controller

This block generates the gain coefficient that a downstream sample multiplier applies to an audio path. On a mute request the coefficient glides from full scale down to exactly zero along an S-shaped curve, and on release it glides back up. The curve moves slowly near both ends, which keeps the transition inaudible. The request is the OR of an external pin and a control-register bit. A two-bit select sets the ramp duration to one of three lengths. The lengths stand in the ratio of roughly 0.48 ms, 0.96 ms and 123 ms once the divider parameters are scaled to the system clock.

A ramp that has started always runs to its end. When it reaches its end the request is looked at again. If the request now calls for the other direction, the opposite ramp begins. A status output is high from the first cycle of muting until the end of the following demute. A separate hard-mute input forces the coefficient to zero in the same cycle without disturbing the ramp state, which keeps moving underneath.

Top module: `smute_ramp_ctrl`

## Requirements
- R1: After reset, gain_o equals full scale FULL = 2^GAIN_W-1 and busy_o is 0.
- R2: The request is mute_pin_i OR mute_reg_i. When the block is at full gain and not ramping, either input being high at a clock edge starts a falling ramp at that edge.
- R3: During a ramp the level index moves one step every D cycles, so a full ramp lasts STEPS*D cycles. D is chosen from ramp_sel_i at the edge where the ramp starts: 0 selects DIV_FAST, 1 selects DIV_MID, and 2 or 3 select DIV_SLOW. A change of ramp_sel_i during a ramp has no effect on that ramp.
- R4: At level index k (0..STEPS), and with hard mute low, gain_o = floor(FULL*(3*k*k*STEPS - 2*k*k*k)/STEPS^3). The muted end is therefore exactly 0 and the open end is exactly FULL.
- R5: A change of the request during a ramp is ignored, and the ramp continues to its end.
- R6: At the end of a falling ramp, if the request is low on the following edge, a rising ramp starts on that edge. At the end of a rising ramp, busy_o is 0 for one cycle; if the request is high on the next edge, a new falling ramp starts there.
- R7: busy_o rises on the edge that starts a falling ramp and stays high until the edge that completes the rising ramp.
- R8: While hard_mute_i is high, gain_o is 0 in the same cycle and busy_o is unaffected. After release, gain_o shows the curve value of the ramp position, which has advanced as if hard mute had not been applied.
- R9: While the request stays high after a falling ramp, gain_o stays 0 and busy_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mute_pin_i | input | 1 | Mute request from external pin (synchronised upstream) |
| mute_reg_i | input | 1 | Mute request from control register |
| hard_mute_i | input | 1 | Immediate zero-gain override |
| ramp_sel_i | input | 2 | Ramp duration select (0 fast, 1 mid, 2/3 slow) |
| gain_o | output | GAIN_W | Gain coefficient for the sample multiplier |
| busy_o | output | 1 | Mute sequence in progress |

## Verification
Two events can land in the same cycle: a request change can arrive exactly as a ramp completes, and a hard mute can overlap a ramp step. The bench provokes the first by withdrawing the request early in a falling ramp, then raising it again during the rise, so that each ramp end finds a reversed request. It judges the exact edges at which the reverse ramps start and busy_o dips. For the second, it raises hard mute while steps keep happening and checks that gain_o is zero throughout. After release, gain_o must equal the curve value of the advanced position. A behavioural model is compared with both outputs on every cycle.

// File: rtl/smute_pkg.sv
package smute_pkg;
  typedef enum logic [1:0] {ST_OPEN, ST_FALL, ST_SHUT, ST_RISE} smute_st_e;

  // smoothstep: full*(3k^2 n - 2k^3)/n^3
  function automatic longint unsigned s_curve(int unsigned k, int unsigned n, int unsigned w);
    longint unsigned full, kk, nn, num, den;
    full = (64'd1 << w) - 64'd1;
    kk   = longint'(k);
    nn   = longint'(n);
    num  = 3 * kk * kk * nn - 2 * kk * kk * kk;
    den  = nn * nn * nn;
    return (full * num) / den;
  endfunction
endpackage

// File: rtl/smute_rate.sv
module smute_rate #(
  parameter int DIV_FAST = 3,
  parameter int DIV_MID  = 6,
  parameter int DIV_SLOW = 768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  output logic       step_o
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_MID) ? ((DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST)
                                                : ((DIV_MID > DIV_FAST) ? DIV_MID : DIV_FAST);
  localparam int CNT_W = $clog2(DIV_MAX + 1);

  logic [CNT_W-1:0] div_q, div_d, cnt_q;

  always_comb begin
    unique case (sel_i)
      2'd0:    div_d = CNT_W'(DIV_FAST);
      2'd1:    div_d = CNT_W'(DIV_MID);
      default: div_d = CNT_W'(DIV_SLOW);
    endcase
  end

  assign step_o = run_i && (cnt_q == div_q - 1'b1);

  // duration latched at ramp start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= CNT_W'(DIV_FAST);
      cnt_q <= '0;
    end else if (start_i) begin
      div_q <= div_d;
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= step_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/smute_curve.sv
module smute_curve #(
  parameter int STEPS  = 16,
  parameter int GAIN_W = 16,
  localparam int LVL_W = $clog2(STEPS + 1)
) (
  input  logic [LVL_W-1:0]  lvl_i,
  output logic [GAIN_W-1:0] gain_o
);
  logic [GAIN_W-1:0] tbl [STEPS+1];

  for (genvar k = 0; k <= STEPS; k++) begin : g_tbl
    assign tbl[k] = GAIN_W'(smute_pkg::s_curve(k, STEPS, GAIN_W));
  end

  assign gain_o = tbl[lvl_i];
endmodule

// File: rtl/smute_ramp_ctrl.sv
module smute_ramp_ctrl #(
  parameter int GAIN_W   = 16,
  parameter int STEPS    = 16,
  parameter int DIV_FAST = 3,
  parameter int DIV_MID  = 6,
  parameter int DIV_SLOW = 768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mute_pin_i,
  input  logic              mute_reg_i,
  input  logic              hard_mute_i,
  input  logic [1:0]        ramp_sel_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic              busy_o
);
  import smute_pkg::*;
  localparam int LVL_W = $clog2(STEPS + 1);
  localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(STEPS);

  smute_st_e         st_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              req, start, run, step;
  logic [GAIN_W-1:0] curve_gain;

  assign req   = mute_pin_i | mute_reg_i;
  assign start = (st_q == ST_OPEN && req) || (st_q == ST_SHUT && !req);
  assign run   = (st_q == ST_FALL) || (st_q == ST_RISE);

  smute_rate #(
    .DIV_FAST (DIV_FAST),
    .DIV_MID  (DIV_MID),
    .DIV_SLOW (DIV_SLOW)
  ) u_rate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .run_i   (run),
    .sel_i   (ramp_sel_i),
    .step_o  (step)
  );

  smute_curve #(
    .STEPS  (STEPS),
    .GAIN_W (GAIN_W)
  ) u_curve (
    .lvl_i  (lvl_q),
    .gain_o (curve_gain)
  );

  // request only sampled outside a ramp
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_OPEN;
      lvl_q <= LVL_TOP;
    end else begin
      unique case (st_q)
        ST_OPEN: if (req) st_q <= ST_FALL;
        ST_FALL: if (step) begin
          lvl_q <= lvl_q - 1'b1;
          if (lvl_q == LVL_W'(1)) st_q <= ST_SHUT;
        end
        ST_SHUT: if (!req) st_q <= ST_RISE;
        ST_RISE: if (step) begin
          lvl_q <= lvl_q + 1'b1;
          if (lvl_q == LVL_TOP - 1'b1) st_q <= ST_OPEN;
        end
        default: st_q <= ST_OPEN;
      endcase
    end
  end

  assign busy_o = (st_q != ST_OPEN);
  assign gain_o = hard_mute_i ? '0 : curve_gain;
endmodule

// File: rtl/smute_ramp_chk.sv
module smute_ramp_chk #(
  parameter int GAIN_W = 16,
  parameter int STEPS  = 16,
  localparam int LVL_W = $clog2(STEPS + 1)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  mute_pin_i,
  input logic                  mute_reg_i,
  input logic                  hard_mute_i,
  input logic [GAIN_W-1:0]     gain_o,
  input logic                  busy_o,
  input smute_pkg::smute_st_e  st_q,
  input logic [LVL_W-1:0]      lvl_q
);
  import smute_pkg::*;
  localparam logic [GAIN_W-1:0] FULL = '1;
  logic req;
  assign req = mute_pin_i | mute_reg_i;

  // R2
  req_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OPEN && req) |=> (st_q == ST_FALL));

  // R3
  lvl_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(lvl_q) == int'($past(lvl_q))) || (int'(lvl_q) == int'($past(lvl_q)) + 1)
    || (int'(lvl_q) + 1 == int'($past(lvl_q))));

  // R5
  fall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FALL) |=> (st_q == ST_FALL || st_q == ST_SHUT));

  // R5
  rise_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RISE) |=> (st_q == ST_RISE || st_q == ST_OPEN));

  // R6
  resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SHUT && !req) |=> (st_q == ST_RISE));

  // R7
  idle_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !hard_mute_i) |-> (gain_o == FULL));

  // R8
  hard_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_mute_i |-> (gain_o == '0));

  // R9
  shut_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SHUT && req) |=> (st_q == ST_SHUT && gain_o == '0 && busy_o));
endmodule

bind smute_ramp_ctrl smute_ramp_chk #(.GAIN_W(GAIN_W), .STEPS(STEPS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mute_pin_i  (mute_pin_i),
  .mute_reg_i  (mute_reg_i),
  .hard_mute_i (hard_mute_i),
  .gain_o      (gain_o),
  .busy_o      (busy_o),
  .st_q        (st_q),
  .lvl_q       (lvl_q)
);

// File: tb/sim_smute_ramp_ctrl.sv
`timescale 1ns/1ps
module sim_smute_ramp_ctrl;
  localparam int GW = 16;
  localparam int NS = 16;
  localparam int DF = 3;
  localparam int DM = 6;
  localparam int DS = 768;
  localparam longint FULL = (64'd1 << GW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, reg_b = 1'b0, hard = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [GW-1:0] gain;
  logic busy;

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R1";

  smute_ramp_ctrl #(.GAIN_W(GW), .STEPS(NS), .DIV_FAST(DF), .DIV_MID(DM), .DIV_SLOW(DS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mute_pin_i(pin), .mute_reg_i(reg_b),
    .hard_mute_i(hard), .ramp_sel_i(sel), .gain_o(gain), .busy_o(busy));

  always #5 clk = ~clk;

  function automatic longint curve(int k);
    longint kk = k;
    return (FULL * (3 * kk * kk * NS - 2 * kk * kk * kk)) / (NS * NS * NS);
  endfunction

  function automatic int div_of(logic [1:0] s);
    return (s == 2'd0) ? DF : (s == 2'd1) ? DM : DS;
  endfunction

  task automatic chk(input bit ok, input string t, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  // reference: 0 open, 1 falling, 2 shut, 3 rising
  int m_st = 0, m_lvl = NS, m_cnt = 0, m_div = DF;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_lvl = NS; m_cnt = 0; m_div = DF;
    end else begin
      case (m_st)
        0: if (pin | reg_b) begin m_st = 1; m_cnt = 0; m_div = div_of(sel); end
        1: if (m_cnt == m_div - 1) begin
             m_cnt = 0; m_lvl--; if (m_lvl == 0) m_st = 2;
           end else m_cnt++;
        2: if (!(pin | reg_b)) begin m_st = 3; m_cnt = 0; m_div = div_of(sel); end
        default: if (m_cnt == m_div - 1) begin
             m_cnt = 0; m_lvl++; if (m_lvl == NS) m_st = 0;
           end else m_cnt++;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      longint eg;
      eg = hard ? 0 : curve(m_lvl);
      chk(gain == GW'(eg), {tag, " gain"}, gain, eg);
      chk(busy == (m_st != 0), {tag, " busy"}, busy, m_st != 0);
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    #1;
    // R1
    chk(gain == GW'(FULL), "R1 reset gain", gain, FULL);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    step(3);

    // R2 pin request, fast ramp, R3 duration, R9 hold
    tag = "R2"; sel = 2'd0; pin = 1'b1;
    step(1);
    chk(busy == 1'b1, "R7 busy at start", busy, 1);
    tag = "R3";
    step(NS * DF - 1);
    chk(gain == GW'(curve(1)), "R4 last nonzero", gain, curve(1));
    step(1);
    chk(gain == 0, "R3 fast end", gain, 0);
    tag = "R9";
    step(20);
    chk(gain == 0 && busy, "R9 hold shut", gain, 0);
    tag = "R7"; pin = 1'b0;
    step(1 + NS * DF - 1);
    chk(busy == 1'b1, "R7 busy before end", busy, 1);
    step(1);
    chk(busy == 1'b0 && gain == GW'(FULL), "R7 busy after end", busy, 0);
    step(5);

    // R2 register request, mid ramp; R4 midpoint
    tag = "R2"; sel = 2'd1; reg_b = 1'b1;
    step(1);
    step(NS / 2 * DM);
    chk(gain == GW'(curve(NS / 2)), "R4 midpoint", gain, curve(NS / 2));
    tag = "R3";
    step(NS / 2 * DM - 1);
    chk(gain == GW'(curve(1)), "R3 mid near end", gain, curve(1));
    step(1);
    chk(gain == 0, "R3 mid end", gain, 0);
    reg_b = 1'b0;
    step(1 + NS * DM + 4);

    // R5 withdrawn request ignored; R6 reversal at ends
    tag = "R5"; sel = 2'd0; pin = 1'b1;
    step(1);
    step(10);
    pin = 1'b0;
    step(NS * DF - 10);
    chk(gain == 0 && busy, "R5 fall completes", gain, 0);
    tag = "R6";
    step(1);
    chk(gain == 0 && busy, "R6 rise begins", gain, 0);
    step(DF);
    chk(gain == GW'(curve(1)), "R6 rise first step", gain, curve(1));
    pin = 1'b1;
    step(NS * DF - DF);
    chk(gain == GW'(FULL) && !busy, "R5 rise completes", busy, 0);
    step(1);
    chk(busy == 1'b1, "R6 refall starts", busy, 1);
    pin = 1'b0;
    step(2 * NS * DF + 6);

    // R8 hard mute over a running ramp and while idle
    tag = "R8"; reg_b = 1'b1;
    step(1);
    step(20);
    hard = 1'b1;
    step(1);
    chk(gain == 0 && busy, "R8 hard during ramp", gain, 0);
    step(10);
    hard = 1'b0;
    step(1);
    chk(gain == GW'(curve(NS - 10)), "R8 release value", gain, curve(NS - 10));
    reg_b = 1'b0;
    step(2 * NS * DF + 6);
    hard = 1'b1;
    step(2);
    chk(gain == 0 && !busy, "R8 hard idle", busy, 0);
    hard = 1'b0;
    step(1);
    chk(gain == GW'(FULL), "R8 idle release", gain, FULL);

    // R3 slow ramp, select latched; code 3 maps to slow
    tag = "R3"; sel = 2'd2; pin = 1'b1;
    step(1);
    sel = 2'd0;
    step(NS * DS - 1);
    chk(gain == GW'(curve(1)), "R3 slow latched", gain, curve(1));
    step(1);
    chk(gain == 0, "R3 slow end", gain, 0);
    sel = 2'd3; pin = 1'b0;
    step(1);
    step(NS * DS - 1);
    chk(busy == 1'b1, "R3 code3 slow busy", busy, 1);
    step(1);
    chk(gain == GW'(FULL) && !busy, "R3 code3 slow end", gain, FULL);
    step(4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule